// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo PCM stream into parallel samples. The three wires are a bit clock, a word clock and serial data. The stream can use one of four framings: left-justified, I²S, right-justified 24-bit or right-justified 20-bit. A small format field picks the framing. The field is captured only while the power-down input is high, so a running receiver never changes framing in the middle of a stream.

The serial lines are treated as asynchronous to the system clock. They are synchronized into the system clock domain, and rising bit-clock edges are detected there. For each word-clock half, the block collects data into two structures:
- a positional collector, which places the bits that follow the half's first bit clock (left-justified) or its second bit clock (I²S);
- a trailing shift register, which keeps the last bits of the half (right-justified).

When the word clock changes, the half that just ended is turned into a 24-bit sample. The left sample is held. When the right half ends, both outputs update together and a one-cycle strobe marks the new frame.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, `left_smp` and `right_smp` are zero and `frame_vld` is low.
- R2: Left-justified framing is `fmt` value 0. The left channel is the word-clock-high half. The sample MSB is the bit on the first rising bit-clock edge of the half, and the following 23 bits fill the sample down to the LSB.
- R3: I²S framing is `fmt` value 1. The left channel is the word-clock-low half. The MSB is the bit on the second rising bit-clock edge of the half, one bit clock after the word-clock change.
- R4: Right-justified 24-bit framing is `fmt` value 2. The left channel is the high half, and the sample is the last 24 bits of the half. Halves are 32 bit clocks long.
- R5: Right-justified 20-bit framing is `fmt` value 3. The last 20 bits of the half go to `*_smp[23:4]`, and `*_smp[3:0]` is zero.
- R6: `frame_vld` pulses for exactly one cycle per frame. The pulse comes after the right half has ended, which is detected at the first bit-clock rise of the following half. Both sample outputs change only in that cycle.
- R7: `fmt` is captured only while `pwr_dn` is high. Changes to `fmt` while `pwr_dn` is low have no effect on decoding.
- R8: While `pwr_dn` is high, both samples read zero and `frame_vld` stays low. After `pwr_dn` is released, any half that began before the first observed word-clock change is discarded. No frame is produced until a complete left half has been followed by a complete right half.
- R9: In the left-justified and I²S framings, bits of a half after the 24 sample bits are ignored.
- R10: `fmt` values 4 to 7 decode as left-justified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down; holds the receiver idle and opens the format capture |
| fmt | input | 3 | Framing select, captured during power-down |
| bck | input | 1 | Serial bit clock (asynchronous) |
| wck | input | 1 | Word clock marking channel halves (asynchronous) |
| sdata | input | 1 | Serial audio data, MSB first |
| left_smp | output | 24 | Left-channel sample |
| right_smp | output | 24 | Right-channel sample |
| frame_vld | output | 1 | One-cycle strobe when a new stereo frame is presented |

## Verification
The bench builds the receiver with its default parameters:
- 24-bit samples, a 20-bit short format, 32-bit halves and a two-stage synchronizer;
- a bit-clock period of eight system clocks, so synchronizer latency never merges edges.

Each 32-bit half has enough spare slots to put alternating filler before the right-justified samples and after the left-justified and I²S samples. This shows whether the filler leaks into a sample. It also exposes the padding in the 20-bit format.

The bench uses the same parameter set to reach the other cases:
- a partial first half after power-up;
- a format change attempted while running;
- the aliased format codes.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    FMT_LEFT = 2'd0,
    FMT_I2S  = 2'd1,
    FMT_RJ24 = 2'd2,
    FMT_RJ20 = 2'd3
  } fmt_e;

  // R10: the upper half of the code space folds onto left-justified
  function automatic fmt_e decode_fmt(input logic [2:0] code);
    if (code[2]) return FMT_LEFT;
    return fmt_e'(code[1:0]);
  endfunction

endpackage

// File: rtl/aud_line_sync.sv
module aud_line_sync #(
  parameter int LINES    = 3,
  parameter int STAGES   = 2,
  parameter int EDGE_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl,
  output logic             rise
);

  logic [LINES-1:0] stage_q [STAGES];
  logic             edge_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_d_q <= 1'b0;
    else        edge_d_q <= stage_q[STAGES-1][EDGE_BIT];
  end

  assign lvl  = stage_q[STAGES-1];
  assign rise = stage_q[STAGES-1][EDGE_BIT] & ~edge_d_q;

endmodule

// File: rtl/aud_slot_collect.sv
module aud_slot_collect
  import aud_rx_pkg::*;
#(
  parameter int SW        = 24,
  parameter int SHORT_W   = 20,
  parameter int SLOT_BITS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bit_stb,
  input  logic          wck_lvl,
  input  logic          sd_lvl,
  input  fmt_e          fmt,
  output logic          half_done,
  output logic          half_lvl,
  output logic [SW-1:0] half_smp
);

  localparam int POS_W = $clog2(SLOT_BITS) + 1;
  localparam int PAD_W = SW - SHORT_W;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             wck_prev_q, wck_prev_n;
  logic             armed_q, armed_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic [SW-1:0]    acc_q, acc_n;
  logic [SW-1:0]    tail_q, tail_n;
  logic             done_q, done_n;
  logic             lvl_q, lvl_n;
  logic [SW-1:0]    smp_q, smp_n;

  logic             trans;
  logic             is_i2s;
  logic             in_win;
  logic [POS_W-1:0] off;

  assign trans  = (wck_lvl != wck_prev_q);
  assign is_i2s = (fmt == FMT_I2S);

  always_comb begin
    wck_prev_n = wck_prev_q;
    armed_n    = armed_q;
    pos_n      = pos_q;
    acc_n      = acc_q;
    tail_n     = tail_q;
    done_n     = 1'b0;
    lvl_n      = lvl_q;
    smp_n      = smp_q;
    in_win     = 1'b0;
    off        = '0;
    if (clr) begin
      wck_prev_n = wck_lvl;
      armed_n    = 1'b0;
      pos_n      = '0;
      acc_n      = '0;
      tail_n     = '0;
    end else if (bit_stb) begin
      wck_prev_n = wck_lvl;
      if (trans) begin
        // the half that just ended becomes a sample; the current bit opens a new half
        done_n  = armed_q;
        armed_n = 1'b1;
        lvl_n   = wck_prev_q;
        case (fmt)
          FMT_RJ24: smp_n = tail_q;
          FMT_RJ20: smp_n = {tail_q[SHORT_W-1:0], {PAD_W{1'b0}}};
          default:  smp_n = acc_q;
        endcase
        pos_n  = '0;
        acc_n  = '0;
        tail_n = {{(SW-1){1'b0}}, sd_lvl};
      end else begin
        pos_n  = (pos_q == POS_MAX) ? pos_q : pos_q + POS_W'(1);
        tail_n = {tail_q[SW-2:0], sd_lvl};
      end
      if (is_i2s) begin
        in_win = (pos_n != '0) && (pos_n <= POS_W'(SW));
        off    = pos_n - POS_W'(1);
      end else begin
        in_win = (pos_n < POS_W'(SW));
        off    = pos_n;
      end
      for (int k = 0; k < SW; k++) begin
        if (in_win && (off == POS_W'(SW - 1 - k))) acc_n[k] = sd_lvl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wck_prev_q <= 1'b0;
      armed_q    <= 1'b0;
      pos_q      <= '0;
      acc_q      <= '0;
      tail_q     <= '0;
      done_q     <= 1'b0;
      lvl_q      <= 1'b0;
      smp_q      <= '0;
    end else begin
      wck_prev_q <= wck_prev_n;
      armed_q    <= armed_n;
      pos_q      <= pos_n;
      acc_q      <= acc_n;
      tail_q     <= tail_n;
      done_q     <= done_n;
      lvl_q      <= lvl_n;
      smp_q      <= smp_n;
    end
  end

  assign half_done = done_q;
  assign half_lvl  = lvl_q;
  assign half_smp  = smp_q;

  // R6: a finished half is reported for one cycle only
  p_half_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    half_done |=> !half_done);

  // R8: nothing is reported while held in power-down
  p_half_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !half_done);

endmodule

// File: rtl/aud_frame_pack.sv
module aud_frame_pack #(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          left_lvl,
  input  logic          half_done,
  input  logic          half_lvl,
  input  logic [SW-1:0] half_smp,
  output logic [SW-1:0] left_smp,
  output logic [SW-1:0] right_smp,
  output logic          frame_vld
);

  logic [SW-1:0] hold_q, hold_n;
  logic          hold_ok_q, hold_ok_n;
  logic [SW-1:0] left_q, left_n;
  logic [SW-1:0] right_q, right_n;
  logic          vld_q, vld_n;

  always_comb begin
    hold_n    = hold_q;
    hold_ok_n = hold_ok_q;
    left_n    = left_q;
    right_n   = right_q;
    vld_n     = 1'b0;
    if (clr) begin
      hold_n    = '0;
      hold_ok_n = 1'b0;
      left_n    = '0;
      right_n   = '0;
    end else if (half_done) begin
      if (half_lvl == left_lvl) begin
        hold_n    = half_smp;
        hold_ok_n = 1'b1;
      end else if (hold_ok_q) begin
        left_n    = hold_q;
        right_n   = half_smp;
        vld_n     = 1'b1;
        hold_ok_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_ok_q <= 1'b0;
      left_q    <= '0;
      right_q   <= '0;
      vld_q     <= 1'b0;
    end else begin
      hold_q    <= hold_n;
      hold_ok_q <= hold_ok_n;
      left_q    <= left_n;
      right_q   <= right_n;
      vld_q     <= vld_n;
    end
  end

  assign left_smp  = left_q;
  assign right_smp = right_q;
  assign frame_vld = vld_q;

  // R6: strobe is a single-cycle pulse
  p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld);

  // R6: outputs move only together with the strobe
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (frame_vld || ($stable(left_smp) && $stable(right_smp))));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SHORT_W     = 20,
  parameter int SLOT_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_dn,
  input  logic [2:0]          fmt,
  input  logic                bck,
  input  logic                wck,
  input  logic                sdata,
  output logic [SAMPLE_W-1:0] left_smp,
  output logic [SAMPLE_W-1:0] right_smp,
  output logic                frame_vld
);

  localparam int LINES = 3;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i = rst_pipe_q[1];

  // format capture (R7)
  logic [2:0] fmt_q, fmt_n;
  fmt_e       fmt_sel;

  always_comb begin
    fmt_n = fmt_q;
    if (pwr_dn) fmt_n = fmt;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) fmt_q <= 3'd0;
    else        fmt_q <= fmt_n;
  end

  assign fmt_sel = decode_fmt(fmt_q);

  logic [LINES-1:0] lines_lvl;
  logic             bck_rise;

  aud_line_sync #(
    .LINES   (LINES),
    .STAGES  (SYNC_STAGES),
    .EDGE_BIT(0)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_i),
    .raw  ({sdata, wck, bck}),
    .lvl  (lines_lvl),
    .rise (bck_rise)
  );

  logic                half_done;
  logic                half_lvl;
  logic [SAMPLE_W-1:0] half_smp;

  aud_slot_collect #(
    .SW       (SAMPLE_W),
    .SHORT_W  (SHORT_W),
    .SLOT_BITS(SLOT_BITS)
  ) u_collect (
    .clk      (clk),
    .rst_n    (rst_i),
    .clr      (pwr_dn),
    .bit_stb  (bck_rise),
    .wck_lvl  (lines_lvl[1]),
    .sd_lvl   (lines_lvl[2]),
    .fmt      (fmt_sel),
    .half_done(half_done),
    .half_lvl (half_lvl),
    .half_smp (half_smp)
  );

  logic left_lvl;
  assign left_lvl = (fmt_sel != FMT_I2S);

  aud_frame_pack #(
    .SW(SAMPLE_W)
  ) u_pack (
    .clk      (clk),
    .rst_n    (rst_i),
    .clr      (pwr_dn),
    .left_lvl (left_lvl),
    .half_done(half_done),
    .half_lvl (half_lvl),
    .half_smp (half_smp),
    .left_smp (left_smp),
    .right_smp(right_smp),
    .frame_vld(frame_vld)
  );

  // R7: the captured format is frozen while running
  p_fmt_hold_r7: assert property (@(posedge clk) disable iff (!rst_i)
    !pwr_dn |=> $stable(fmt_q));

  // R8: no strobe while powered down
  p_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_i)
    pwr_dn |=> !frame_vld);

  // R5: the 20-bit framing leaves the low nibble clear
  p_rj20_pad_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (frame_vld && fmt_sel == FMT_RJ20) |-> (left_smp[3:0] == 4'h0 && right_smp[3:0] == 4'h0));

endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;

  logic        clk;
  logic        rst_n;
  logic        pwr_dn;
  logic [2:0]  fmt;
  logic        bck;
  logic        wck;
  logic        sdata;
  logic [23:0] left_smp;
  logic [23:0] right_smp;
  logic        frame_vld;

  int compared;
  int mismatched;

  logic [23:0] exp_l_q [$];
  logic [23:0] exp_r_q [$];
  string       tag_q   [$];

  serial_audio_rx uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .fmt      (fmt),
    .bck      (bck),
    .wck      (wck),
    .sdata    (sdata),
    .left_smp (left_smp),
    .right_smp(right_smp),
    .frame_vld(frame_vld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // framing model: bit at position p of a half carrying sample s
  function automatic logic bit_of(input int f, input logic [23:0] s, input int p);
    logic junk;
    junk = p[0];
    case (f)
      1:       return (p >= 1 && p <= 24) ? s[24-p] : junk;
      2:       return (p >= 8) ? s[31-p] : junk;
      3:       return (p >= 12) ? s[31-p] : junk;
      default: return (p < 24) ? s[23-p] : junk;
    endcase
  endfunction

  function automatic logic [23:0] exp_of(input int f, input logic [23:0] s);
    if (f == 3) return {s[19:0], 4'h0};
    return s;
  endfunction

  function automatic logic [23:0] val(input int k);
    case (k % 8)
      0: return 24'h800000;
      1: return 24'h7FFFFF;
      2: return 24'h000001;
      3: return 24'hFFFFFF;
      4: return 24'hA5A5A5;
      5: return 24'h5A5A5A;
      default: return 24'(k * 32'h0013_579B + 32'h0024_6801);
    endcase
  endfunction

  task automatic send_half(input int f, input logic lvl, input logic [23:0] s, input int nbits);
    for (int p = 0; p < nbits; p++) begin
      @(negedge clk);
      wck   = lvl;
      sdata = bit_of(f, s, p);
      bck   = 1'b0;
      repeat (4) @(negedge clk);
      bck = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic power_cycle(input logic [2:0] code, input logic idle_lvl);
    @(negedge clk);
    pwr_dn = 1'b1;
    fmt    = code;
    wck    = idle_lvl;
    bck    = 1'b0;
    repeat (10) @(negedge clk);
    pwr_dn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_group(input string req);
    repeat (40) @(negedge clk);
    compared++;
    if (exp_l_q.size() != 0) begin
      mismatched++;
      $display("FAIL %s missing frames actual=0 expected=%0d", req, exp_l_q.size());
      exp_l_q.delete();
      exp_r_q.delete();
      tag_q.delete();
    end
  endtask

  // driver: send frames in framing f after power-up with pin code
  task automatic run_group(input logic [2:0] code, input logic [2:0] run_code,
                           input int f, input int nframes, input int seed, input string req);
    logic ll;
    ll = (f == 1) ? 1'b0 : 1'b1;
    power_cycle(code, ~ll);
    fmt = run_code;
    send_half(f, ~ll, 24'h0, 32);
    for (int i = 0; i < nframes; i++) begin
      exp_l_q.push_back(exp_of(f, val(seed + 2*i)));
      exp_r_q.push_back(exp_of(f, val(seed + 2*i + 1)));
      tag_q.push_back(req);
      send_half(f, ll, val(seed + 2*i), 32);
      send_half(f, ~ll, val(seed + 2*i + 1), 32);
    end
    send_half(f, ll, 24'h0, 32);
    finish_group(req);
  endtask

  // monitor: pop and compare on each strobe
  always @(negedge clk) begin
    if (rst_n && frame_vld) begin
      if (exp_l_q.size() == 0) begin
        compared++;
        mismatched++;
        $display("FAIL R6 unexpected frame actual=%h/%h expected=none", left_smp, right_smp);
      end else begin
        string t;
        logic [23:0] el, er;
        t  = tag_q.pop_front();
        el = exp_l_q.pop_front();
        er = exp_r_q.pop_front();
        check({t, " left"}, left_smp, el);
        check({t, " right"}, right_smp, er);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    compared   = 0;
    mismatched = 0;
    rst_n  = 1'b0;
    pwr_dn = 1'b1;
    fmt    = 3'd0;
    bck    = 1'b0;
    wck    = 1'b0;
    sdata  = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 left", left_smp, 24'h0);
    check("R1 right", right_smp, 24'h0);
    check("R1 strobe", {23'h0, frame_vld}, 24'h0);

    // R2, R9 left-justified with trailing filler
    run_group(3'd0, 3'd0, 0, 3, 0, "R2/R9 LJ");
    // R3, R9 I2S
    run_group(3'd1, 3'd1, 1, 3, 2, "R3/R9 I2S");
    // R4 right-justified 24
    run_group(3'd2, 3'd2, 2, 3, 4, "R4 RJ24");
    // R5 right-justified 20
    run_group(3'd3, 3'd3, 3, 3, 6, "R5 RJ20");
    // R10 aliased code
    run_group(3'd5, 3'd5, 0, 2, 9, "R10 code5");
    // R7 pin changed while running: still RJ24
    run_group(3'd2, 3'd0, 2, 2, 13, "R7 fmt frozen");

    // R8 outputs cleared in power-down
    @(negedge clk);
    pwr_dn = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 pd left", left_smp, 24'h0);
    check("R8 pd right", right_smp, 24'h0);

    // R8 partial first half and orphan right half are discarded
    power_cycle(3'd0, 1'b1);
    send_half(0, 1'b1, val(3), 10);
    send_half(0, 1'b0, val(4), 32);
    exp_l_q.push_back(val(20));
    exp_r_q.push_back(val(21));
    tag_q.push_back("R8 partial start");
    send_half(0, 1'b1, val(20), 32);
    send_half(0, 1'b0, val(21), 32);
    send_half(0, 1'b1, 24'h0, 32);
    finish_group("R8 partial start");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule